// File: doc/BRIEF.md
# Deep Sleep Watchdog Timer

This block is a timeout counter that keeps running while the rest of the chip is in deep sleep. It counts edges of a low-frequency clock. Each low-frequency source is presented to the block as a one-cycle tick strobe in the always-on `clk` domain, together with a level that says whether that oscillator is stable. A configuration bit picks the source. The watchdog has its own enable and does not depend on any other watchdog.

Each deep-sleep entry strobe does three things. It clears the count, and it captures the source select and the 5-bit postscaler code. If the chosen oscillator is not ready at that moment, the block raises a request for it by itself and holds off counting until the oscillator reports ready. When the count reaches its terminal value, the block emits a single timeout pulse that wakes the device. The request is dropped when the device leaves deep sleep or the enable is cleared.

Postscaler code `n` selects a terminal count of 2^(n+`TICK_SHIFT`) counted ticks. With the default `TICK_SHIFT` of 5, code 0 gives 32 ticks and code 31 gives 2^36 ticks.

Top module: `dsw_watchdog`

## Requirements
- R1: After reset, `timeout_o`, `sosc_req_o` and `lprc_req_o` are low, and no timeout occurs until an entry strobe arrives while enabled.
- R2: An entry strobe taken while `wdt_en_i` is low raises no request and leads to no timeout, whatever ticks follow.
- R3: `clk_sel_i` is sampled at entry: 0 selects the secondary-oscillator source (`sosc_*`) and 1 selects the low-power RC source (`lprc_*`). Ticks on the other source are ignored.
- R4: With captured code n, the 2^(n+TICK_SHIFT)-th counted tick makes `timeout_o` high for exactly one `clk` cycle, in the cycle after the edge that sampled that tick.
- R5: If the selected source's ready is low at entry, its request output goes high in the cycle after entry and the other request stays low. Ticks are ignored until ready is seen high.
- R6: If the selected source's ready is high at entry, no request is raised.
- R7: A tick that arrives while the selected ready is low is not counted.
- R8: A new entry strobe during counting restarts the count from zero.
- R9: In the cycle after `sleep_exit_i` is high, or after `wdt_en_i` is low, both requests and `timeout_o` are low, and counting has stopped until the next enabled entry.
- R10: Changes to `ps_code_i` or `clk_sel_i` after entry do not affect the running timeout.
- R11: Only one timeout pulse follows each entry. Further ticks produce no pulse until the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| wdt_en_i | input | 1 | Watchdog enable configuration bit |
| clk_sel_i | input | 1 | Source select: 0 secondary oscillator, 1 low-power RC |
| ps_code_i | input | CODE_W | Postscaler code n |
| sleep_entry_i | input | 1 | One-cycle deep-sleep entry strobe |
| sleep_exit_i | input | 1 | One-cycle deep-sleep exit strobe |
| sosc_tick_i | input | 1 | One-cycle tick per secondary-oscillator period |
| sosc_ready_i | input | 1 | Secondary oscillator running and stable |
| lprc_tick_i | input | 1 | One-cycle tick per low-power RC period |
| lprc_ready_i | input | 1 | Low-power RC running and stable |
| sosc_req_o | output | 1 | Request to start the secondary oscillator |
| lprc_req_o | output | 1 | Request to start the low-power RC |
| timeout_o | output | 1 | One-cycle timeout / wake pulse |

## Verification
The bench builds the block with `CODE_W` left at 5 and `TICK_SHIFT` lowered to 2. With these values, code 0 expires after 4 ticks and code 1 after 8, so every expiry, restart and ignored-tick case runs in a few hundred cycles. The full 5-bit code path is still exercised: code 3 is loaded mid-sleep to show that the captured code is the one that counts. The 34-bit counter width that follows from these parameters is elaborated but never filled.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [1:0] {
    DSW_IDLE = 2'd0,
    DSW_WAIT = 2'd1,
    DSW_RUN  = 2'd2,
    DSW_DONE = 2'd3
  } dsw_state_e;

  localparam int N_SRC = 2;
  localparam logic SRC_SOSC = 1'b0;
  localparam logic SRC_LPRC = 1'b1;
endpackage

// File: rtl/dsw_src_sel.sv
module dsw_src_sel
  import dsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             cfg_src_i,
  input  logic [N_SRC-1:0] tick_vec_i,
  input  logic [N_SRC-1:0] ready_vec_i,
  output logic             pick_o,
  output logic             pick_ready_o,
  output logic             sel_tick_o,
  output logic             sel_ready_o
);
  logic src_q;

  always_ff @(posedge clk) begin
    if (rst)         src_q <= SRC_SOSC;
    else if (load_i) src_q <= cfg_src_i;
  end

  // source being chosen this cycle (entry) versus the one held during sleep
  assign pick_o       = load_i ? cfg_src_i : src_q;
  assign pick_ready_o = ready_vec_i[pick_o];
  assign sel_tick_o   = tick_vec_i[src_q];
  assign sel_ready_o  = ready_vec_i[src_q];
endmodule

// File: rtl/dsw_ctrl.sv
module dsw_ctrl
  import dsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             entry_i,
  input  logic             exit_i,
  input  logic             pick_i,
  input  logic             pick_ready_i,
  input  logic             sel_tick_i,
  input  logic             sel_ready_i,
  input  logic             expire_i,
  output logic             arm_o,
  output logic             adv_o,
  output logic [N_SRC-1:0] req_o
);
  dsw_state_e state_q;
  logic       quiet;
  logic [N_SRC-1:0] req_q;
  logic [N_SRC-1:0] pick_hot;

  assign quiet = !en_i || exit_i;
  assign arm_o = !quiet && entry_i;
  assign adv_o = !quiet && !entry_i && (state_q == DSW_RUN) && sel_ready_i && sel_tick_i;

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_hot
      assign pick_hot[s] = (pick_i == s[0]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DSW_IDLE;
      req_q   <= '0;
    end else if (quiet) begin
      state_q <= DSW_IDLE;
      req_q   <= '0;
    end else if (entry_i) begin
      state_q <= pick_ready_i ? DSW_RUN : DSW_WAIT;
      req_q   <= pick_ready_i ? '0 : pick_hot;
    end else begin
      case (state_q)
        DSW_WAIT: if (sel_ready_i) state_q <= DSW_RUN;
        DSW_RUN:  if (expire_i)    state_q <= DSW_DONE;
        default:  state_q <= state_q;
      endcase
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/dsw_count.sv
module dsw_count #(
  parameter int CODE_W     = 5,
  parameter int TICK_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              expire_o,
  output logic              pulse_o
);
  localparam int CNT_W = TICK_SHIFT + (1 << CODE_W);

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last;
  logic              pulse_q;

  assign last     = (CNT_W'(1) << (CNT_W'(code_q) + CNT_W'(TICK_SHIFT))) - CNT_W'(1);
  assign expire_o = adv_i && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      code_q <= code_i;
    end else if (adv_i) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= expire_o;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/dsw_watchdog.sv
module dsw_watchdog
  import dsw_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int TICK_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdt_en_i,
  input  logic              clk_sel_i,
  input  logic [CODE_W-1:0] ps_code_i,
  input  logic              sleep_entry_i,
  input  logic              sleep_exit_i,
  input  logic              sosc_tick_i,
  input  logic              sosc_ready_i,
  input  logic              lprc_tick_i,
  input  logic              lprc_ready_i,
  output logic              sosc_req_o,
  output logic              lprc_req_o,
  output logic              timeout_o
);
  logic             arm, adv, expire;
  logic             pick, pick_ready, sel_tick, sel_ready;
  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] tick_vec, ready_vec;

  assign tick_vec  = {lprc_tick_i, sosc_tick_i};
  assign ready_vec = {lprc_ready_i, sosc_ready_i};

  dsw_src_sel u_sel (
    .clk(clk), .rst(rst), .load_i(arm), .cfg_src_i(clk_sel_i),
    .tick_vec_i(tick_vec), .ready_vec_i(ready_vec),
    .pick_o(pick), .pick_ready_o(pick_ready),
    .sel_tick_o(sel_tick), .sel_ready_o(sel_ready)
  );

  dsw_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en_i(wdt_en_i), .entry_i(sleep_entry_i),
    .exit_i(sleep_exit_i), .pick_i(pick), .pick_ready_i(pick_ready),
    .sel_tick_i(sel_tick), .sel_ready_i(sel_ready), .expire_i(expire),
    .arm_o(arm), .adv_o(adv), .req_o(req)
  );

  dsw_count #(.CODE_W(CODE_W), .TICK_SHIFT(TICK_SHIFT)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(arm), .adv_i(adv), .code_i(ps_code_i),
    .expire_o(expire), .pulse_o(timeout_o)
  );

  assign sosc_req_o = req[SRC_SOSC];
  assign lprc_req_o = req[SRC_LPRC];
endmodule

// File: rtl/dsw_watchdog_chk.sv
module dsw_watchdog_chk (
  input logic clk,
  input logic rst,
  input logic wdt_en_i,
  input logic clk_sel_i,
  input logic sleep_entry_i,
  input logic sleep_exit_i,
  input logic sosc_tick_i,
  input logic sosc_ready_i,
  input logic lprc_tick_i,
  input logic lprc_ready_i,
  input logic sosc_req_o,
  input logic lprc_req_o,
  input logic timeout_o
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);                                           // R4
  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> $past(sosc_tick_i || lprc_tick_i));                    // R4
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sosc_req_o, lprc_req_o}));                                 // R5
  AST_SOSC_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(sosc_req_o) |-> $past(sleep_entry_i && wdt_en_i && !clk_sel_i && !sosc_ready_i)); // R5
  AST_LPRC_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(lprc_req_o) |-> $past(sleep_entry_i && wdt_en_i && clk_sel_i && !lprc_ready_i));  // R5
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wdt_en_i |=> (!sosc_req_o && !lprc_req_o && !timeout_o));           // R9
  AST_EXIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    sleep_exit_i |=> (!sosc_req_o && !lprc_req_o && !timeout_o));        // R9
endmodule

bind dsw_watchdog dsw_watchdog_chk u_chk (
  .clk(clk), .rst(rst), .wdt_en_i(wdt_en_i), .clk_sel_i(clk_sel_i),
  .sleep_entry_i(sleep_entry_i), .sleep_exit_i(sleep_exit_i),
  .sosc_tick_i(sosc_tick_i), .sosc_ready_i(sosc_ready_i),
  .lprc_tick_i(lprc_tick_i), .lprc_ready_i(lprc_ready_i),
  .sosc_req_o(sosc_req_o), .lprc_req_o(lprc_req_o), .timeout_o(timeout_o)
);

// File: tb/dsw_watchdog_bench.sv
`timescale 1ns/1ps
module dsw_watchdog_bench;
  localparam int CODE_W = 5;
  localparam int SHIFT  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, sel = 1'b0, ent = 1'b0, ext = 1'b0;
  logic st = 1'b0, lt = 1'b0, srdy = 1'b1, lrdy = 1'b1;
  logic [CODE_W-1:0] code = '0;
  logic sreq, lreq, tmo;

  int n_chk = 0, n_fail = 0, edge_n = 0;
  bit finished = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  dsw_watchdog #(.CODE_W(CODE_W), .TICK_SHIFT(SHIFT)) u_dsw_watchdog (
    .clk(clk), .rst(rst), .wdt_en_i(en), .clk_sel_i(sel), .ps_code_i(code),
    .sleep_entry_i(ent), .sleep_exit_i(ext), .sosc_tick_i(st), .sosc_ready_i(srdy),
    .lprc_tick_i(lt), .lprc_ready_i(lrdy), .sosc_req_o(sreq), .lprc_req_o(lreq),
    .timeout_o(tmo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: every timeout pulse must match the head of the expected queue
  always @(negedge clk) begin
    if (!rst && !finished && tmo) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected timeout", edge_n, -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(edge_n == e, t, edge_n, e);
      end
    end
  end

  task automatic drive(input logic e, input logic x, input logic s, input logic l);
    @(negedge clk);
    ent = e; ext = x; st = s; lt = l;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  // n ticks on source src; optionally expect a timeout from the last one
  task automatic ticks(input bit src, input int n, input bit push_last, input string tag);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, src == 1'b0, src == 1'b1);
      if (push_last && i == n - 1) begin
        exp_q.push_back(edge_n + 1);
        tag_q.push_back(tag);
      end
      drive(0, 0, 0, 0);
    end
  endtask

  task automatic check_reqs(input logic es, input logic el, input string tag);
    chk(sreq == es, {tag, " sosc_req"}, sreq, es);
    chk(lreq == el, {tag, " lprc_req"}, lreq, el);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", edge_n, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1: quiet after reset
    check_reqs(0, 0, "R1");
    chk(tmo == 1'b0, "R1 timeout", tmo, 0);
    ticks(0, 10, 0, "R1");

    // R2: entry while disabled does nothing
    en = 0; sel = 0; code = 0;
    drive(1, 0, 0, 0); idle(1);
    check_reqs(0, 0, "R2");
    ticks(0, 10, 0, "R2");

    // R6 R4 R3 R11: secondary source ready, code 0 = 4 ticks
    en = 1; sel = 0; code = 0;
    drive(1, 0, 0, 0); idle(1);
    check_reqs(0, 0, "R6");
    ticks(0, 4, 1, "R4 code0 sosc");
    ticks(0, 8, 0, "R11");

    // R3: lprc selected, sosc ticks ignored, code 1 = 8 ticks
    sel = 1; code = 1;
    drive(1, 0, 0, 0); idle(1);
    ticks(0, 10, 0, "R3");
    ticks(1, 8, 1, "R3 lprc code1");

    // R5: lprc not ready at entry
    sel = 1; code = 0; lrdy = 0;
    drive(1, 0, 0, 0); idle(1);
    check_reqs(0, 1, "R5");
    ticks(1, 5, 0, "R5");
    lrdy = 1;
    idle(2);
    ticks(1, 4, 1, "R5 after ready");
    check_reqs(0, 1, "R5 held");
    drive(0, 1, 0, 0); idle(1);
    check_reqs(0, 0, "R9 exit");

    // R7: ready drops mid-count
    sel = 0; code = 0;
    drive(1, 0, 0, 0); idle(1);
    ticks(0, 2, 0, "R7");
    srdy = 0;
    ticks(0, 3, 0, "R7");
    srdy = 1;
    ticks(0, 2, 1, "R7 resume");

    // R8: re-entry restarts the count, code 1 = 8 ticks
    code = 1;
    drive(1, 0, 0, 0); idle(1);
    ticks(0, 5, 0, "R8");
    drive(1, 0, 0, 0); idle(1);
    ticks(0, 7, 0, "R8");
    ticks(0, 1, 1, "R8 restart");

    // R10: config changed after entry is ignored
    sel = 0; code = 0;
    drive(1, 0, 0, 0); idle(1);
    sel = 1; code = 3;
    ticks(1, 6, 0, "R10");
    ticks(0, 4, 1, "R10 captured cfg");

    // R9: disable drops request and stops counting
    sel = 0; code = 0; srdy = 0;
    drive(1, 0, 0, 0); idle(1);
    check_reqs(1, 0, "R5 sosc");
    en = 0;
    idle(1);
    check_reqs(0, 0, "R9 disable");
    en = 1; srdy = 1;
    ticks(0, 10, 0, "R9");

    // R9: exit while counting stops it
    drive(1, 0, 0, 0); idle(1);
    ticks(0, 2, 0, "R9");
    drive(0, 1, 0, 0);
    ticks(0, 10, 0, "R9");

    idle(4);
    chk(exp_q.size() == 0, "R4 missing timeout", exp_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule